// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block is a direct-mapped table of 2-bit saturating counters that sits beside the instruction fetch stage. On every cycle the fetch address is presented on the lookup port. Its low-order word-index bits select one counter, and the block returns a taken or not-taken guess in the same cycle with no register in the path. When fetch sees a taken guess, it steers to the branch target as soon as that target is known.

When a branch resolves later in the pipeline, its address and real direction are presented on the update port. The selected counter moves one step toward the real outcome and stops at either end of its range. The table keeps no tags, so two branches whose addresses share the index bits use the same counter.

Each counter has two states on each side of the decision. This means a prediction reverses only after two wrong guesses in a row. As a result, a loop branch that is taken many times and then falls through is mispredicted once per pass, not twice.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not-taken). Every lookup then predicts not-taken, and a single taken update to an entry makes that entry predict taken.
- R2: The entry is selected by lookup/update address bits [IDX_W+1:2], where IDX_W = log2(DEPTH). Bits [1:0] and all bits above the index have no effect on which entry is used, so aliasing addresses share one counter.
- R3: An update with taken=1 adds one to the selected counter and saturates at 2'b11 (strongly taken).
- R4: An update with taken=0 subtracts one from the selected counter and saturates at 2'b00 (strongly not-taken).
- R5: The prediction is bit 1 of the counter (1 = taken). From either saturated state, two consecutive opposite outcomes are needed to reverse the prediction, and one is not enough.
- R6: The lookup output is combinational from the lookup address in the same cycle. An update takes effect at the clock edge where it is presented.
- R7: When an update and a lookup select the same entry in one cycle, the lookup returns the value from before that update.
- R8: With the update valid low, the table does not change whatever the update address and outcome inputs carry. An update to one entry does not change any other entry.
- R9: For a loop branch taken N times and then not taken, once it is trained each later pass of the loop produces exactly one misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| lookupPc | input | PC_W | Fetch address to predict for |
| predictTaken | output | 1 | 1 = predict taken for lookupPc |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
A corrupted counter becomes visible at the ports only through the prediction bit. A counter stuck or wrapped past its limit shows up as a wrong guess only after one or two more updates of the same sign have pushed it across the decision boundary. The checks therefore drive entries to each saturated end, apply several extra updates there, and then count exactly how many opposite updates the prediction needs before it flips. An index taken from the wrong address bits shows up on the very next lookup, as a prediction change at an aliased or neighbouring address.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Strobes from control to datapath for one update.
  typedef struct packed {
    logic wrEn;
    logic inc;
    logic dec;
  } bhtStrobe_t;

endpackage

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  ctr_t       updCur,
  output bhtStrobe_t strb
);

  logic atCeiling;
  logic atFloor;

  always_comb begin
    atCeiling = (updCur == CTR_STRONG_T);
    atFloor   = (updCur == CTR_STRONG_NT);
    strb.inc  = updValid && updTaken && !atCeiling;
    strb.dec  = updValid && !updTaken && !atFloor;
    strb.wrEn = strb.inc || strb.dec;
  end

endmodule

// File: rtl/bht_datapath.sv
module bht_datapath
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] updPc,
  input  bhtStrobe_t      strb,
  output logic            predictTaken,
  output ctr_t            updCur
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0] lookupIdx;
  logic [IDX_W-1:0] updIdx;
  ctr_t             entryState [DEPTH];
  ctr_t             nextVal;
  logic             unusedPcBits;

  assign lookupIdx = lookupPc[IDX_HI:IDX_LO];
  assign updIdx    = updPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1], updPc[IDX_LO-1:0]};

  assign updCur  = entryState[updIdx];
  assign nextVal = strb.inc ? ctr_t'(updCur + 2'd1) : ctr_t'(updCur - 2'd1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    ctr_t q;
    logic hit;
    assign hit = strb.wrEn && (updIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    q <= CTR_WEAK_NT;
      else if (hit) q <= nextVal;
    end
    assign entryState[i] = q;
  end

  // Read is from the registered state, so a same-cycle write is not seen.
  assign predictTaken = entryState[lookupIdx][1];

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predictTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  bhtStrobe_t strobes;
  ctr_t       updCur;

  bht_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCur   (updCur),
    .strb     (strobes)
  );

  bht_datapath #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .lookupPc     (lookupPc),
    .updPc        (updPc),
    .strb         (strobes),
    .predictTaken (predictTaken),
    .updCur       (updCur)
  );

endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic            predictTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic [1:0]      updCur
);

  // R8: without an update the prediction for a held address is unchanged
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updValid) && $stable(lookupPc)) |-> $stable(predictTaken));

  // R4: a prediction falls only after a not-taken update to that entry
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(predictTaken) && $stable(lookupPc)) |->
      ($past(updValid) && !$past(updTaken) &&
       ($past(updPc[IDX_W+1:2]) == lookupPc[IDX_W+1:2])));

  // R3: a prediction rises only after a taken update to that entry
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(predictTaken) && $stable(lookupPc)) |->
      ($past(updValid) && $past(updTaken) &&
       ($past(updPc[IDX_W+1:2]) == lookupPc[IDX_W+1:2])));

  // R3: a taken update at the ceiling leaves the counter at the ceiling
  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && updCur == 2'b11) |=>
      (!$stable(updPc) || updCur == 2'b11));

  // R4: a not-taken update at the floor leaves the counter at the floor
  p_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && updCur == 2'b00) |=>
      (!$stable(updPc) || updCur == 2'b00));

endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W), .IDX_W($clog2(DEPTH))) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .lookupPc     (lookupPc),
  .predictTaken (predictTaken),
  .updValid     (updValid),
  .updPc        (updPc),
  .updTaken     (updTaken),
  .updCur       (updCur)
);

// File: tb/bht_predictor_tb.sv
`timescale 1ns/100ps
module bht_predictor_tb;

  localparam int PC_W  = 32;
  localparam int DEPTH = 64;
  localparam int SPAN  = DEPTH * 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic            predictTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bht_predictor #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(predictTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetDut();
    updValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc, output logic p);
    @(negedge clk);
    lookupPc = pc;
    #0.5 p = predictTaken;
  endtask

  task automatic testReset();
    logic p;
    resetDut();
    look(32'h0000_0000, p); check("R1 reset pc0", p, 0);
    look(32'h0000_00FC, p); check("R1 reset last entry", p, 0);
    look(32'h1234_5678, p); check("R1 reset random pc", p, 0);
    upd(32'h0000_0010, 1'b1);
    look(32'h0000_0010, p); check("R1 weak state flips on one taken", p, 1);
  endtask

  task automatic testSatTaken();
    logic p;
    resetDut();
    for (int i = 0; i < 5; i++) upd(32'h0000_0020, 1'b1);
    look(32'h0000_0020, p); check("R3 after five taken", p, 1);
    upd(32'h0000_0020, 1'b0);
    look(32'h0000_0020, p); check("R5 one not-taken from strong taken", p, 1);
    upd(32'h0000_0020, 1'b0);
    look(32'h0000_0020, p); check("R3 ceiling held, second not-taken flips", p, 0);
  endtask

  task automatic testSatNotTaken();
    logic p;
    resetDut();
    for (int i = 0; i < 5; i++) upd(32'h0000_0030, 1'b0);
    look(32'h0000_0030, p); check("R4 after five not-taken", p, 0);
    upd(32'h0000_0030, 1'b1);
    look(32'h0000_0030, p); check("R5 one taken from strong not-taken", p, 0);
    upd(32'h0000_0030, 1'b1);
    look(32'h0000_0030, p); check("R4 floor held, second taken flips", p, 1);
  endtask

  task automatic testIndex();
    logic p;
    resetDut();
    upd(32'h0000_0104, 1'b1);
    look(32'h0000_0104 + SPAN, p); check("R2 alias above index", p, 1);
    look(32'h0000_0107, p);        check("R2 byte offset ignored", p, 1);
    look(32'h0000_0108, p);        check("R2 next entry untouched", p, 0);
    look(32'h0000_0100, p);        check("R2 previous entry untouched", p, 0);
    upd(32'hF000_0106, 1'b0);
    look(32'h0000_0104, p);        check("R2 alias update shared", p, 0);
  endtask

  task automatic testSameCycle();
    resetDut();
    @(negedge clk);
    lookupPc = 32'h0000_0040;
    updValid = 1'b1; updPc = 32'h0000_0040; updTaken = 1'b1;
    #0.5 check("R7 same-cycle lookup sees old value", predictTaken, 0);
    @(negedge clk);
    updValid = 1'b0;
    #0.5 check("R6 update visible next cycle", predictTaken, 1);
  endtask

  task automatic testIdle();
    logic p;
    resetDut();
    upd(32'h0000_0050, 1'b1);
    @(negedge clk);
    lookupPc = 32'h0000_0050;
    for (int i = 0; i < 6; i++) begin
      updPc = 32'h0000_0050; updTaken = i[0];
      @(negedge clk);
    end
    #0.5 check("R8 invalid update ignored", predictTaken, 1);
    upd(32'h0000_0054, 1'b0);
    upd(32'h0000_0054, 1'b0);
    look(32'h0000_0050, p); check("R8 other entry update isolated", p, 1);
  endtask

  task automatic testLoop();
    logic p;
    int miss;
    resetDut();
    for (int pass = 0; pass < 3; pass++) begin
      miss = 0;
      for (int it = 0; it < 5; it++) begin
        look(32'h0000_0080, p);
        if (p != (it < 4)) miss++;
        upd(32'h0000_0080, it < 4);
      end
      if (pass > 0) check("R9 one miss per trained loop pass", miss, 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testSatTaken();
    testSatNotTaken();
    testIndex();
    testSameCycle();
    testIdle();
    testLoop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule